// File: doc/BRIEF.md
# Weighted correlator score combiner

This block turns the eight per-stage agreement counts of a binary correlator array into one correlation score. Depending on the configured mode, the stage counts are summed with equal weight, combined as binary-weighted bit planes of a multi-bit word, or split into two independent four-stage halves. A programmable offset is added to the sum, and the result enters a delay line. The line's length can be set from 1 to 16 cycles, so that several devices wired in a daisy chain produce aligned scores.

The delayed score is added to the score arriving from the upstream device, and the total leaves on the cascade output. The first device in a chain has zero on its cascade input. In dual mode the second half's score, with its own offset, appears on a separate output after one cycle. The dual-mode delay is always one cycle, whatever the delay code says.

Top module: `corr_score_combiner`

## Requirements
- R1: With mode 2'b00 (single), the pre-delay score is the sum of all eight stage counts plus offsetA. Stage k occupies stageCnt[6k+5:6k].
- R2: With mode 2'b01 (multi-bit), stage k is shifted left by k before summing, so stage 7 carries the most significant weight. offsetA is then added.
- R3: The offsets are unsigned 13-bit values. Every sum wraps modulo 8192.
- R4: Outside dual mode, a pre-delay score that is captured at a clock edge reaches casOut after delayCode+1 edges.
- R5: With mode 2'b10 (dual), casOut carries stages 0 to 3 summed plus offsetA. scoreB carries stages 4 to 7 summed plus offsetB.
- R6: In dual mode both halves have a delay of exactly one edge, and delayCode has no effect.
- R7: casOut equals the delayed score plus the present casIn, modulo 8192, with no register between casIn and casOut.
- R8: When mode was not dual at the previous edge, scoreB is zero.
- R9: A synchronous reset clears the delay line. After a reset edge, casOut equals casIn and scoreB is zero.
- R10: Mode 2'b11 behaves exactly like single mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| stageCnt | input | 48 | Eight 6-bit stage counts, stage k at bits 6k+5:6k |
| mode | input | 2 | 00 single, 01 multi-bit, 10 dual, 11 single |
| offsetA | input | 13 | Offset for the main or A score |
| offsetB | input | 13 | Offset for the B half in dual mode |
| delayCode | input | 4 | Delay line length minus one |
| casIn | input | 13 | Score from the upstream device |
| casOut | output | 13 | Delayed local score plus casIn |
| scoreB | output | 13 | Dual-mode B half score, zero otherwise |

## Verification
The hardest situation to reach is a change of delay code or mode while older scores are still in flight. The tap then moves to entries that were captured under different settings. To reach it, the stimulus holds random modes and codes for short runs of cycles and changes them mid-stream. Meanwhile the bench keeps a 16-deep history of its own expected pre-delay scores, so every tap position is checked against the correct older sample. Directed cases add full-scale counts with large offsets and cascade inputs to force the 13-bit wrap, and add a reset in mid-stream.

// File: rtl/corr_score_pkg.sv
package corr_score_pkg;
  localparam int STAGES  = 8;
  localparam int CNT_W   = 6;
  localparam int SCORE_W = 13;
  localparam int DEPTH   = 16;
  localparam int CODE_W  = $clog2(DEPTH);

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_MULTI  = 2'b01,
    MODE_DUAL   = 2'b10,
    MODE_ALT    = 2'b11
  } corrMode_e;

  typedef struct packed {
    logic              shiftEn;
    logic              dualEn;
    logic [CODE_W-1:0] tapSel;
  } combCtl_t;
endpackage

// File: rtl/corr_score_ctl.sv
module corr_score_ctl
  import corr_score_pkg::*;
(
  input  logic [1:0]        mode,
  input  logic [CODE_W-1:0] delayCode,
  output combCtl_t          ctl
);
  corrMode_e modeE;

  always_comb begin
    modeE      = corrMode_e'(mode);
    ctl        = '0;
    ctl.shiftEn = (modeE == MODE_MULTI);
    ctl.dualEn  = (modeE == MODE_DUAL);
    // dual mode pins the tap to the first stage
    ctl.tapSel  = ctl.dualEn ? '0 : delayCode;
  end
endmodule

// File: rtl/corr_score_dp.sv
module corr_score_dp
  import corr_score_pkg::*;
#(
  parameter int NUM_STAGES = STAGES,
  parameter int CW         = CNT_W,
  parameter int SW         = SCORE_W,
  parameter int LINE_DEPTH = DEPTH
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_STAGES*CW-1:0] stageCnt,
  input  logic [SW-1:0]            offsetA,
  input  logic [SW-1:0]            offsetB,
  input  logic [SW-1:0]            casIn,
  input  combCtl_t                 ctl,
  output logic [SW-1:0]            casOut,
  output logic [SW-1:0]            scoreB
);
  localparam int HALF = NUM_STAGES / 2;

  logic [SW-1:0] sumA, sumB, laneAIn, laneBIn;
  logic [SW-1:0] lineA [LINE_DEPTH];
  logic [SW-1:0] regB;

  always_comb begin
    logic [SW-1:0] term;
    sumA = '0;
    sumB = '0;
    for (int k = 0; k < NUM_STAGES; k++) begin
      term = SW'(stageCnt[k*CW +: CW]);
      if (ctl.shiftEn) term = term << k;
      if (ctl.dualEn && k >= HALF) sumB = sumB + term;
      else                         sumA = sumA + term;
    end
    laneAIn = sumA + offsetA;
    laneBIn = ctl.dualEn ? (sumB + offsetB) : '0;
  end

  generate
    for (genvar g = 0; g < LINE_DEPTH; g++) begin : g_line
      if (g == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) lineA[g] <= '0;
          else     lineA[g] <= laneAIn;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst) lineA[g] <= '0;
          else     lineA[g] <= lineA[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) regB <= '0;
    else     regB <= laneBIn;
  end

  assign casOut = lineA[ctl.tapSel] + casIn;
  assign scoreB = regB;
endmodule

// File: rtl/corr_score_combiner.sv
module corr_score_combiner
  import corr_score_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic [STAGES*CNT_W-1:0]    stageCnt,
  input  logic [1:0]                 mode,
  input  logic [SCORE_W-1:0]         offsetA,
  input  logic [SCORE_W-1:0]         offsetB,
  input  logic [CODE_W-1:0]          delayCode,
  input  logic [SCORE_W-1:0]         casIn,
  output logic [SCORE_W-1:0]         casOut,
  output logic [SCORE_W-1:0]         scoreB
);
  combCtl_t ctl;

  corr_score_ctl u_ctl (
    .mode      (mode),
    .delayCode (delayCode),
    .ctl       (ctl)
  );

  corr_score_dp u_dp (
    .clk      (clk),
    .rst      (rst),
    .stageCnt (stageCnt),
    .offsetA  (offsetA),
    .offsetB  (offsetB),
    .casIn    (casIn),
    .ctl      (ctl),
    .casOut   (casOut),
    .scoreB   (scoreB)
  );
endmodule

// File: rtl/corr_score_checker.sv
module corr_score_checker
  import corr_score_pkg::*;
(
  input logic                    clk,
  input logic                    rst,
  input logic [STAGES*CNT_W-1:0] stageCnt,
  input logic [1:0]              mode,
  input logic [SCORE_W-1:0]      offsetA,
  input logic [SCORE_W-1:0]      offsetB,
  input logic [CODE_W-1:0]       delayCode,
  input logic [SCORE_W-1:0]      casIn,
  input logic [SCORE_W-1:0]      casOut,
  input logic [SCORE_W-1:0]      scoreB
);
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  function automatic logic [SCORE_W-1:0] refSum(input logic [STAGES*CNT_W-1:0] c,
                                                input int lo, input int hi, input bit shifted);
    logic [SCORE_W-1:0] acc;
    acc = '0;
    for (int k = lo; k <= hi; k++)
      acc = acc + (shifted ? (SCORE_W'(c[k*CNT_W +: CNT_W]) << k) : SCORE_W'(c[k*CNT_W +: CNT_W]));
    return acc;
  endfunction

  logic [SCORE_W-1:0] localPart;
  logic               tapZero;
  assign localPart = casOut - casIn;
  assign tapZero   = (mode == 2'b10) || (delayCode == '0);

  // R9
  p_reset_clear_r9: assert property (@(posedge clk)
    started && $past(rst) |-> (casOut == casIn) && (scoreB == '0));

  // R5
  p_dual_b_r5: assert property (@(posedge clk) disable iff (rst)
    started && !$past(rst) && $past(mode) == 2'b10 |->
      scoreB == $past(refSum(stageCnt, 4, 7, 1'b0) + offsetB));

  // R8
  p_b_idle_r8: assert property (@(posedge clk) disable iff (rst)
    started && !$past(rst) && $past(mode) != 2'b10 |-> scoreB == '0);

  // R1
  p_single_d1_r1: assert property (@(posedge clk) disable iff (rst)
    started && !$past(rst) && tapZero && $past(mode[1]) == $past(mode[0]) |->
      localPart == $past(refSum(stageCnt, 0, 7, 1'b0) + offsetA));

  // R2
  p_multi_d1_r2: assert property (@(posedge clk) disable iff (rst)
    started && !$past(rst) && tapZero && $past(mode) == 2'b01 |->
      localPart == $past(refSum(stageCnt, 0, 7, 1'b1) + offsetA));
endmodule

bind corr_score_combiner corr_score_checker u_chk (
  .clk(clk), .rst(rst), .stageCnt(stageCnt), .mode(mode),
  .offsetA(offsetA), .offsetB(offsetB), .delayCode(delayCode),
  .casIn(casIn), .casOut(casOut), .scoreB(scoreB)
);

// File: tb/corr_score_combiner_bench.sv
`timescale 1ns/1ps
module corr_score_combiner_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [47:0] stageCnt = '0;
  logic [1:0]  mode = 2'b00;
  logic [12:0] offsetA = '0, offsetB = '0, casIn = '0;
  logic [3:0]  delayCode = '0;
  logic [12:0] casOut, scoreB;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [12:0] histA [16];
  logic [12:0] histB;

  always #4 clk = ~clk;

  corr_score_combiner u_corr_score_combiner (
    .clk(clk), .rst(rst), .stageCnt(stageCnt), .mode(mode),
    .offsetA(offsetA), .offsetB(offsetB), .delayCode(delayCode),
    .casIn(casIn), .casOut(casOut), .scoreB(scoreB)
  );

  function automatic logic [12:0] expA(input logic [47:0] c, input logic [1:0] m, input logic [12:0] off);
    logic [12:0] acc = '0;
    int hi = (m == 2'b10) ? 3 : 7;
    for (int k = 0; k <= hi; k++)
      acc = acc + ((m == 2'b01) ? (13'(c[k*6 +: 6]) << k) : 13'(c[k*6 +: 6]));
    return acc + off;
  endfunction

  function automatic logic [12:0] expB(input logic [47:0] c, input logic [1:0] m, input logic [12:0] off);
    logic [12:0] acc = '0;
    if (m != 2'b10) return '0;
    for (int k = 4; k <= 7; k++) acc = acc + 13'(c[k*6 +: 6]);
    return acc + off;
  endfunction

  task automatic chk(input string tag, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic string modeTag(input logic [1:0] m);
    case (m)
      2'b00: return "R1";
      2'b01: return "R2/R4";
      2'b10: return "R5/R6";
      default: return "R10";
    endcase
  endfunction

  // called just after a negedge with inputs applied
  task automatic cycle(input bit doCheck, input string tag);
    int tap;
    #1;
    tap = (mode == 2'b10) ? 0 : int'(delayCode);
    if (doCheck) begin
      chk({tag, " casOut R7"}, casOut, histA[tap] + casIn);
      chk({tag, " scoreB R8"}, scoreB, histB);
    end
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < 16; i++) histA[i] = '0;
      histB = '0;
    end else begin
      for (int i = 15; i > 0; i--) histA[i] = histA[i-1];
      histA[0] = expA(stageCnt, mode, offsetA);
      histB    = expB(stageCnt, mode, offsetB);
    end
    @(negedge clk);
  endtask

  function automatic logic [47:0] allCnt(input logic [5:0] v);
    return {8{v}};
  endfunction

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks + 0);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) histA[i] = '0;
    histB = '0;
    @(negedge clk);
    rst = 1'b1;
    repeat (3) cycle(1'b0, "");
    rst = 1'b0;
    casIn = 13'd77;
    cycle(1'b1, "R9 reset state");

    // R1 single full counts, delay 1
    stageCnt = allCnt(6'd32); mode = 2'b00; offsetA = 13'd0; delayCode = 4'd0; casIn = '0;
    repeat (3) cycle(1'b1, "R1 full");
    // R2 R3 multi-bit full scale with offset wrap
    mode = 2'b01; offsetA = 13'd100;
    repeat (3) cycle(1'b1, "R2 R3 wrap");
    // R4 longest delay: one pulse then zeros
    delayCode = 4'd15; mode = 2'b00; offsetA = 13'd5; stageCnt = 48'd0;
    cycle(1'b1, "R4");
    stageCnt = allCnt(6'd9);
    cycle(1'b1, "R4");
    stageCnt = 48'd0;
    repeat (18) cycle(1'b1, "R4 delay16");
    // R6 dual ignores code
    mode = 2'b10; delayCode = 4'd7; offsetB = 13'd8000;
    stageCnt = {6'd32, 6'd31, 6'd30, 6'd29, 6'd1, 6'd2, 6'd3, 6'd4};
    repeat (3) cycle(1'b1, "R5 R6 dual");
    // R10 reserved mode
    mode = 2'b11; delayCode = 4'd2;
    repeat (4) cycle(1'b1, "R10");
    // R7 cascade wrap
    casIn = 13'd8191; offsetA = 13'd8191;
    repeat (4) cycle(1'b1, "R7 wrap");
    // R9 mid-run reset
    rst = 1'b1; cycle(1'b0, "");
    rst = 1'b0; casIn = 13'd123;
    cycle(1'b1, "R9 mid reset");

    // constrained random runs with mid-stream setting changes
    for (int run = 0; run < 60; run++) begin
      mode      = 2'($urandom_range(0, 3));
      delayCode = 4'($urandom_range(0, 15));
      offsetA   = 13'($urandom);
      offsetB   = 13'($urandom);
      for (int c = 0; c < 12; c++) begin
        for (int k = 0; k < 8; k++) stageCnt[k*6 +: 6] = 6'($urandom_range(0, 32));
        casIn = ($urandom_range(0, 3) == 0) ? 13'd0 : 13'($urandom);
        cycle(1'b1, modeTag(mode));
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule